// File: doc/BRIEF.md
# Dual Look-Up-Table Logic Cell with Run-Time RAM Mode

This block is one configurable logic cell. It holds two 16-entry, one-bit look-up tables (table A and table B) and a small 8-entry merge table. Each table, addressed by its own four inputs, gives any 4-input function. The merge table combines the two table results with one extra input, `h_in`. The tables are loaded through a configuration port before normal use. After that the cell works as combinational logic.

The same two tables can also be switched to act as writable memory. In dual mode each table is a separate 16x1 synchronous-write, asynchronous-read RAM. In wide mode the two tables form one 32x1 RAM, and `h_in` acts as the fifth address bit.

Two storage elements follow the tables. Each one takes its data from one of the cell's results or from its own direct input. Each element can be set to run as an edge-triggered flip-flop or as a level-sensitive latch, with its own clock polarity. Each element has a set/reset value and can apply it synchronously or asynchronously. A clock enable is shared by both elements. The cell offers two combinational outputs (`out_x`, `out_y`) and two stored outputs (`q`). Control pins are plain levels. No handshake applies, because every result is a pure function of the current inputs and the stored state.

Top module: `lcell_dual_lut`

## Requirements
- R1: While `rst_n` is low, every entry of all three tables and both storage elements are cleared, so `out_x`, `out_y` and `q` read 0.
- R2: With `cfg_we` high at a rising `clk` edge, `cfg_bit` is stored at entry `cfg_addr` of the table picked by `cfg_sel` (0 = table A, 1 = table B, 2 = merge table using the low three address bits, 3 = no table). A configuration write takes priority over a RAM write to the same table in the same cycle.
- R3: In logic mode (`mode` 0 or 3), `out_x` equals entry `a_in` of table A, combinationally, and `ram_we` has no effect on any table.
- R4: Outside wide mode, `out_y` equals bit `4*h_in + 2*Bv + Av` of the merge table. Here Av = A[`a_in`] and Bv = B[`b_in`].
- R5: In dual mode (`mode` 1), `ram_we` high at a rising edge writes `wd_a` to A[`a_in`] and `wd_b` to B[`b_in`]. Reads are asynchronous, so the old entry shows before the edge and the new one after it. With `ram_we` low, nothing is written.
- R6: In wide mode (`mode` 2), the address is {`h_in`,`a_in`}. `h_in`=0 selects table A and `h_in`=1 selects table B at index `a_in`. `out_x` reads the selected entry, and `ram_we` writes `wd_a` to it at the rising edge.
- R7: Storage element i takes its data from the field `st_src[2i+1:2i]`: 0 = `out_x`, 1 = the table B result, 2 = `out_y`, 3 = `din[i]`.
- R8: In flop mode (`st_latch[i]`=0), element i captures its data on the rising `clk` edge when `st_negclk[i]`=0, or on the falling edge when it is 1. It captures only while `ce` is high.
- R9: In latch mode (`st_latch[i]`=1), element i is transparent while `clk` is at its active level (high when `st_negclk[i]`=0, low when it is 1) and `ce` is high. Otherwise it holds its value.
- R10: With `st_srsync[i]`=0, `sr` high forces `q[i]` to `st_srval[i]` at once, overriding the clock and `ce`.
- R11: With `st_srsync[i]`=1, `sr` loads `st_srval[i]` only at the active edge (flop) or while transparent (latch), whatever the level of `ce`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target table of a configuration write |
| cfg_addr | input | 4 | Configuration entry index |
| cfg_bit | input | 1 | Configuration data bit |
| mode | input | 2 | 0/3 logic, 1 dual 16x1 RAM, 2 wide 32x1 RAM |
| ram_we | input | 1 | RAM write enable |
| a_in | input | 4 | Table A inputs / RAM address |
| b_in | input | 4 | Table B inputs / dual-mode B address |
| h_in | input | 1 | Merge-table extra input; fifth address bit in wide mode |
| wd_a | input | 1 | RAM write data for table A (and for wide mode) |
| wd_b | input | 1 | RAM write data for table B in dual mode |
| ce | input | 1 | Shared storage clock enable |
| sr | input | 1 | Shared set/reset request |
| din | input | 2 | Direct data inputs of the storage elements |
| st_src | input | 4 | Data source select, two bits per element |
| st_latch | input | 2 | Per element: 1 = latch, 0 = flip-flop |
| st_negclk | input | 2 | Per element: 1 = inverted clock polarity |
| st_srval | input | 2 | Per element: value loaded by set/reset |
| st_srsync | input | 2 | Per element: 1 = synchronous set/reset |
| out_x | output | 1 | Table A result (selected RAM read in wide mode) |
| out_y | output | 1 | Merge-table result |
| q | output | 2 | Storage element outputs |

## Verification
The logic function is swept over all 512 combinations of `a_in`, `b_in` and `h_in` for three unrelated sets of table contents. A single-product, a parity and an irregular pattern each catch different kinds of address bit swaps or stuck entries. A majority-style merge table separates the order of the merge index bits. The RAM modes are checked in two ways. A write and read over every address tells the two tables apart in wide mode. Before-edge and after-edge samples show that reads are asynchronous and writes are synchronous. The storage elements are driven with data that differs from their held value, so a wrong edge, a missing enable, latch transparency or a misplaced set/reset each leave a visible difference on `q`.

// File: rtl/lcell_pkg.sv
`timescale 1ns/1ps
package lcell_pkg;
  typedef enum logic [1:0] {
    MODE_LOGIC     = 2'd0,
    MODE_DUAL      = 2'd1,
    MODE_WIDE      = 2'd2,
    MODE_LOGIC_ALT = 2'd3
  } cell_mode_e;

  typedef enum logic [1:0] {
    SRC_X   = 2'd0,
    SRC_B   = 2'd1,
    SRC_Y   = 2'd2,
    SRC_DIN = 2'd3
  } st_src_e;

  typedef enum logic [1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_MIX  = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/lcell_table.sv
`timescale 1ns/1ps
// One-bit-wide table of 2**K entries: loaded by configuration, optionally
// rewritten as RAM, read asynchronously.
module lcell_table #(
  parameter int K = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  logic [K-1:0] cfg_addr,
  input  logic         cfg_bit,
  input  logic         ram_we,
  input  logic [K-1:0] ram_addr,
  input  logic         ram_bit,
  input  logic [K-1:0] rd_addr,
  output logic         rd_bit
);
  localparam int DEPTH = 1 << K;

  logic [DEPTH-1:0] bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bits <= '0;
    else if (cfg_we) bits[cfg_addr] <= cfg_bit;
    else if (ram_we) bits[ram_addr] <= ram_bit;
  end

  assign rd_bit = bits[rd_addr];
endmodule

// File: rtl/lcell_store.sv
`timescale 1ns/1ps
// Storage element: flip-flop or latch, selectable polarity, sync/async set-reset.
module lcell_store (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic sr,
  input  logic d,
  input  logic latch_en,
  input  logic neg,
  input  logic srval,
  input  logic srsync,
  output logic q
);
  logic ck_eff;
  logic arst;
  logic fq;
  logic lq;

  assign ck_eff = clk ^ neg;
  assign arst   = sr & ~srsync;

  always_ff @(posedge ck_eff or posedge arst or negedge rst_n) begin
    if (!rst_n)            fq <= 1'b0;
    else if (arst)         fq <= srval;
    else if (sr && srsync) fq <= srval;
    else if (ce)           fq <= d;
  end

  always_latch begin
    if (!rst_n)       lq <= 1'b0;
    else if (arst)    lq <= srval;
    else if (ck_eff) begin
      if (sr && srsync) lq <= srval;
      else if (ce)      lq <= d;
    end
  end

  assign q = latch_en ? lq : fq;
endmodule

// File: rtl/lcell_dual_lut.sv
`timescale 1ns/1ps
module lcell_dual_lut
  import lcell_pkg::*;
#(
  parameter int K   = 4,
  parameter int NST = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [K-1:0]     cfg_addr,
  input  logic             cfg_bit,
  input  logic [1:0]       mode,
  input  logic             ram_we,
  input  logic [K-1:0]     a_in,
  input  logic [K-1:0]     b_in,
  input  logic             h_in,
  input  logic             wd_a,
  input  logic             wd_b,
  input  logic             ce,
  input  logic             sr,
  input  logic [NST-1:0]   din,
  input  logic [2*NST-1:0] st_src,
  input  logic [NST-1:0]   st_latch,
  input  logic [NST-1:0]   st_negclk,
  input  logic [NST-1:0]   st_srval,
  input  logic [NST-1:0]   st_srsync,
  output logic             out_x,
  output logic             out_y,
  output logic [NST-1:0]   q
);
  localparam int NTAB  = 2;
  localparam int MIX_K = 3;

  cell_mode_e md;
  logic       wide;
  logic       dual;

  assign md   = cell_mode_e'(mode);
  assign wide = (md == MODE_WIDE);
  assign dual = (md == MODE_DUAL);

  logic [NTAB-1:0] t_cfg_we;
  logic [NTAB-1:0] t_ram_we;
  logic [NTAB-1:0] t_wbit;
  logic [NTAB-1:0] t_rbit;
  logic [K-1:0]    t_waddr [NTAB];
  logic [K-1:0]    t_raddr [NTAB];

  // table 0 = A, table 1 = B
  always_comb begin
    t_cfg_we[0] = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_A);
    t_cfg_we[1] = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_B);
    t_ram_we[0] = ram_we && (dual || (wide && !h_in));
    t_ram_we[1] = ram_we && (dual || (wide && h_in));
    t_waddr[0]  = a_in;
    t_raddr[0]  = a_in;
    t_wbit[0]   = wd_a;
    t_waddr[1]  = wide ? a_in : b_in;
    t_raddr[1]  = wide ? a_in : b_in;
    t_wbit[1]   = wide ? wd_a : wd_b;
  end

  for (genvar t = 0; t < NTAB; t++) begin : g_tab
    lcell_table #(.K(K)) u_tab (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (t_cfg_we[t]),
      .cfg_addr (cfg_addr),
      .cfg_bit  (cfg_bit),
      .ram_we   (t_ram_we[t]),
      .ram_addr (t_waddr[t]),
      .ram_bit  (t_wbit[t]),
      .rd_addr  (t_raddr[t]),
      .rd_bit   (t_rbit[t])
    );
  end

  logic mix_cfg_we;
  assign mix_cfg_we = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_MIX);

  lcell_table #(.K(MIX_K)) u_mix (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (mix_cfg_we),
    .cfg_addr (cfg_addr[MIX_K-1:0]),
    .cfg_bit  (cfg_bit),
    .ram_we   (1'b0),
    .ram_addr ('0),
    .ram_bit  (1'b0),
    .rd_addr  ({h_in, t_rbit[1], t_rbit[0]}),
    .rd_bit   (out_y)
  );

  assign out_x = (wide && h_in) ? t_rbit[1] : t_rbit[0];

  for (genvar i = 0; i < NST; i++) begin : g_st
    logic d_sel;
    always_comb begin
      case (st_src_e'(st_src[2*i +: 2]))
        SRC_X:   d_sel = out_x;
        SRC_B:   d_sel = t_rbit[1];
        SRC_Y:   d_sel = out_y;
        default: d_sel = din[i];
      endcase
    end

    lcell_store u_st (
      .clk      (clk),
      .rst_n    (rst_n),
      .ce       (ce),
      .sr       (sr),
      .d        (d_sel),
      .latch_en (st_latch[i]),
      .neg      (st_negclk[i]),
      .srval    (st_srval[i]),
      .srsync   (st_srsync[i]),
      .q        (q[i])
    );
  end
endmodule

// File: rtl/lcell_dual_lut_chk.sv
`timescale 1ns/1ps
module lcell_dual_lut_chk #(
  parameter int K   = 4,
  parameter int NST = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_we,
  input logic [1:0]     mode,
  input logic           ram_we,
  input logic [K-1:0]   a_in,
  input logic           h_in,
  input logic           wd_a,
  input logic           sr,
  input logic [NST-1:0] st_srval,
  input logic [NST-1:0] st_srsync,
  input logic           out_x,
  input logic           out_y,
  input logic [NST-1:0] q
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (q == '0 && !out_x && !out_y));

  // R3
  logic_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 2'd0 || mode == 2'd3) && !cfg_we)
    |=> (($stable(a_in) && $stable(mode)) -> $stable(out_x)));

  // R5
  dual_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && ram_we && !cfg_we)
    |=> (($stable(a_in) && $stable(mode)) -> (out_x == $past(wd_a))));

  // R6
  wide_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && ram_we && !cfg_we)
    |=> (($stable(a_in) && $stable(h_in) && $stable(mode)) -> (out_x == $past(wd_a))));

  for (genvar i = 0; i < NST; i++) begin : g_sr
    // R10
    async_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sr && !st_srsync[i] && $stable(st_srval[i])) |-> (q[i] == st_srval[i]));
  end
endmodule

bind lcell_dual_lut lcell_dual_lut_chk #(.K(K), .NST(NST)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .mode      (mode),
  .ram_we    (ram_we),
  .a_in      (a_in),
  .h_in      (h_in),
  .wd_a      (wd_a),
  .sr        (sr),
  .st_srval  (st_srval),
  .st_srsync (st_srsync),
  .out_x     (out_x),
  .out_y     (out_y),
  .q         (q)
);

// File: tb/sim_lcell_dual_lut.sv
`timescale 1ns/1ps
module sim_lcell_dual_lut;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [3:0] cfg_addr = 4'd0;
  logic       cfg_bit = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       ram_we = 1'b0;
  logic [3:0] a_in = 4'd0;
  logic [3:0] b_in = 4'd0;
  logic       h_in = 1'b0;
  logic       wd_a = 1'b0;
  logic       wd_b = 1'b0;
  logic       ce = 1'b0;
  logic       sr = 1'b0;
  logic [1:0] din = 2'd0;
  logic [3:0] st_src = 4'd0;
  logic [1:0] st_latch = 2'd0;
  logic [1:0] st_negclk = 2'd0;
  logic [1:0] st_srval = 2'd0;
  logic [1:0] st_srsync = 2'd0;
  logic       out_x;
  logic       out_y;
  logic [1:0] q;

  int n_run = 0;
  int n_fail = 0;
  logic [15:0] ea = '0;
  logic [15:0] eb = '0;
  logic [7:0]  em = '0;

  always #2 clk = ~clk;

  lcell_dual_lut u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .cfg_bit(cfg_bit), .mode(mode), .ram_we(ram_we),
    .a_in(a_in), .b_in(b_in), .h_in(h_in), .wd_a(wd_a), .wd_b(wd_b),
    .ce(ce), .sr(sr), .din(din), .st_src(st_src), .st_latch(st_latch),
    .st_negclk(st_negclk), .st_srval(st_srval), .st_srsync(st_srsync),
    .out_x(out_x), .out_y(out_y), .q(q)
  );

  task automatic chk(input string req, input logic got, input logic exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic load(input logic [1:0] sel, input logic [15:0] pat, input int n);
    for (int i = 0; i < n; i++) begin
      cfg_we = 1'b1; cfg_sel = sel; cfg_addr = 4'(i); cfg_bit = pat[i];
      tick();
    end
    cfg_we = 1'b0;
    if (sel == 2'd0) ea = pat;
    else if (sel == 2'd1) eb = pat;
    else if (sel == 2'd2) em = pat[7:0];
  endtask

  task automatic sweep();
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int h = 0; h < 2; h++) begin
          a_in = 4'(a); b_in = 4'(b); h_in = h[0];
          #0.2;
          chk("R3", out_x, ea[a]);
          chk("R4", out_y, em[{h[0], eb[b], ea[a]}]);
        end
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] pa [3];
    logic [15:0] pb [3];
    logic [7:0]  pm [3];
    logic [31:0] wpat;
    pa = '{16'h8000, 16'h6996, 16'hB2D4};
    pb = '{16'h0001, 16'hF00F, 16'h5C3A};
    pm = '{8'hE8, 8'h96, 8'h1D};
    wpat = 32'hA5C3_1E96;

    #1 rst_n = 1'b0;
    tick(); tick();
    // R1: cleared state
    chk("R1", out_x, 1'b0);
    chk("R1", out_y, 1'b0);
    chk("R1", q[0], 1'b0);
    chk("R1", q[1], 1'b0);
    rst_n = 1'b1;
    tick();

    // R2 R3 R4: exhaustive logic sweeps for several contents
    for (int p = 0; p < 3; p++) begin
      load(2'd0, pa[p], 16);
      load(2'd1, pb[p], 16);
      load(2'd2, {8'h00, pm[p]}, 8);
      sweep();
    end

    // R2: select 3 touches no table
    load(2'd3, 16'hFFFF, 16);
    for (int a = 0; a < 16; a++) begin
      a_in = 4'(a); #0.2; chk("R2", out_x, ea[a]);
    end

    // R3: ram_we ignored in logic mode
    mode = 2'd0; a_in = 4'd3; wd_a = ~ea[3]; ram_we = 1'b1;
    tick(); ram_we = 1'b0; #0.2;
    chk("R3", out_x, ea[3]);

    // R5: dual RAM mode; merge table passes B through
    load(2'd2, 16'h00CC, 8);
    mode = 2'd1;
    for (int i = 0; i < 16; i++) begin
      a_in = 4'(i); b_in = 4'(15 - i); h_in = 1'b0;
      wd_a = ~ea[i]; wd_b = ~eb[15 - i]; ram_we = 1'b1;
      #0.2;
      chk("R5", out_x, ea[i]);
      chk("R5", out_y, eb[15 - i]);
      tick();
      ea[i] = wd_a; eb[15 - i] = wd_b;
      chk("R5", out_x, ea[i]);
      chk("R5", out_y, eb[15 - i]);
    end
    ram_we = 1'b0;
    a_in = 4'd6; b_in = 4'd9; wd_a = ~ea[6]; wd_b = ~eb[9];
    tick();
    chk("R5", out_x, ea[6]);
    chk("R5", out_y, eb[9]);

    // R2: configuration beats RAM write
    a_in = 4'd5; wd_a = ~ea[5]; ram_we = 1'b1;
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_addr = 4'd5; cfg_bit = ea[5];
    tick();
    cfg_we = 1'b0; ram_we = 1'b0;
    chk("R2", out_x, ea[5]);

    // R6: wide 32x1 RAM
    mode = 2'd2;
    for (int i = 0; i < 32; i++) begin
      a_in = 4'(i); h_in = i[4]; wd_a = wpat[i]; ram_we = 1'b1;
      tick();
      if (i[4]) eb[i[3:0]] = wpat[i]; else ea[i[3:0]] = wpat[i];
    end
    ram_we = 1'b0;
    for (int i = 0; i < 32; i++) begin
      a_in = 4'(i); h_in = i[4]; #0.2;
      chk("R6", out_x, wpat[i]);
    end
    mode = 2'd0; h_in = 1'b0;
    for (int b = 0; b < 16; b++) begin
      b_in = 4'(b); a_in = 4'(b); #0.2;
      chk("R6", out_y, wpat[16 + b]);
      chk("R6", out_x, wpat[b]);
    end

    // R8: element 0 from din, element 1 from out_x
    load(2'd2, 16'h0096, 8);
    st_src = 4'b00_11;
    ce = 1'b1; din[0] = 1'b1;
    tick();
    chk("R8", q[0], 1'b1);
    ce = 1'b0; din[0] = 1'b0;
    tick();
    chk("R8", q[0], 1'b1);
    ce = 1'b1; st_negclk[0] = 1'b1;
    #0.5; chk("R8", q[0], 1'b1);
    #2;   chk("R8", q[0], 1'b0);
    st_negclk[0] = 1'b0; din[0] = 1'b1;
    tick();
    chk("R8", q[0], 1'b1);

    // R9: latch transparency and hold
    st_latch[0] = 1'b1; din[0] = 1'b0;
    #0.5; chk("R9", q[0], 1'b0);
    #1.5; din[0] = 1'b1;
    #0.5; chk("R9", q[0], 1'b0);
    tick();
    #0.2; chk("R9", q[0], 1'b1);
    ce = 1'b0; din[0] = 1'b0;
    #0.3; chk("R9", q[0], 1'b1);
    st_latch[0] = 1'b0; ce = 1'b1;
    tick();
    chk("R8", q[0], 1'b0);

    // R10: asynchronous set
    ce = 1'b0; st_srval[0] = 1'b1; st_srsync[0] = 1'b0; sr = 1'b1;
    #0.5; chk("R10", q[0], 1'b1);
    sr = 1'b0;
    tick();
    chk("R10", q[0], 1'b1);

    // R11: synchronous reset ignores ce
    st_srval[0] = 1'b0; st_srsync[0] = 1'b1;
    #0.1; sr = 1'b1; din[0] = 1'b1;
    #0.3; chk("R11", q[0], 1'b1);
    tick();
    chk("R11", q[0], 1'b0);
    sr = 1'b0;

    // R7: element 1 source selection
    ce = 1'b1;
    for (int s = 0; s < 3; s++)
      for (int k = 0; k < 4; k++) begin
        logic ax, bx, yx, ev;
        st_src[3:2] = 2'(s);
        a_in = 4'(k * 5); b_in = 4'(15 - k * 3); h_in = k[0];
        ax = ea[k * 5]; bx = eb[15 - k * 3]; yx = em[{k[0], bx, ax}];
        ev = (s == 0) ? ax : ((s == 1) ? bx : yx);
        tick();
        chk("R7", q[1], ev);
      end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule